// File: doc/BRIEF.md
# Seven-to-One Serial Lane Word Assembler

This block rebuilds 28-bit parallel words from four serial data lanes and one clock lane. Each lane carries seven bits per word period. The capture logic in front of it samples every lane on both edges of a fast clock that runs at 3.5 times the word rate. The block therefore receives two bits per lane on each fast cycle, a rising-edge sample and a falling-edge sample. Buffers, phase alignment and clock multiplication sit outside it.

A seven-bit word is not a whole number of fast cycles long. A word therefore ends on a falling-edge sample (an even word) or on a rising-edge sample (an odd word), and the two kinds alternate. The block searches the clock lane for its fixed idle group to find the word boundary. It then tracks the boundaries at intervals of four and three fast cycles and selects, through a multiplexer, the window of the matching kind. It emits one 28-bit word per period with a valid strobe. The word is split into three 8-bit image ports and four qualifiers: frame valid, line valid, data valid and a spare bit. Alignment must be confirmed on two consecutive words before any output appears. If the clock group is lost, the block searches again.

Top module: `lvds_deser7`

## Requirements
- R1: On each lane, the rising-edge sample of a fast cycle is earlier in time than the falling-edge sample of the same cycle. Seven consecutive bits form a group, and the earliest bit is group bit 0.
- R2: A word boundary is the position at which the clock-lane group, read in time order, equals 1,1,0,0,0,1,1.
- R3: After reset, `locked` is low and `word_valid` stays low until the clock-lane group has matched on two consecutive words. The second of those words is the first one emitted, and `locked` rises in the same cycle as its `word_valid`. `word_valid` is never high while `locked` is low.
- R4: While locked, a clock-lane group that does not match at an expected boundary clears `locked`. That word is not emitted. The block then searches again and emits nothing until two consecutive matches are seen.
- R5: `word_valid` pulses for one cycle per assembled word. Between consecutive emitted words the gap is 4 fast cycles after an even word and 3 fast cycles after an odd word.
- R6: `word_odd` is 0 for a word whose last bit was a falling-edge sample and 1 for a word whose last bit was a rising-edge sample. Consecutive words alternate.
- R7: Group bit i of data lane L becomes word bit 7L+i. `pix_a` = word[7:0], `pix_b` = word[15:8], `pix_c` = word[23:16], `fval` = word[24], `lval` = word[25], `dval` = word[26], `spare` = word[27].
- R8: While reset is active, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast sampling clock, 3.5x the word rate |
| rst_n | input | 1 | Active-low synchronous reset |
| dat_rise | input | 4 | Rising-edge samples of the four data lanes |
| dat_fall | input | 4 | Falling-edge samples of the four data lanes |
| ck_rise | input | 1 | Rising-edge sample of the clock lane |
| ck_fall | input | 1 | Falling-edge sample of the clock lane |
| pix_a | output | 8 | Image port A |
| pix_b | output | 8 | Image port B |
| pix_c | output | 8 | Image port C |
| fval | output | 1 | Frame valid qualifier |
| lval | output | 1 | Line valid qualifier |
| dval | output | 1 | Data valid qualifier |
| spare | output | 1 | Spare qualifier |
| word_valid | output | 1 | One-cycle strobe per emitted word |
| word_odd | output | 1 | Word ended on a rising-edge sample |
| locked | output | 1 | Word framing confirmed |

## Verification
The cadence and alternation properties assume one thing: once locked, boundaries come only from the tracker, so a search never starts in the middle of a locked run. The properties hold whatever the clock lane carries. The bench loses a word only by replacing its clock group with all zeros. No shifted window across a zero group and a good group can equal the sync group, so the bench's own framing model sees a match only on true boundaries. The bench inserts a random number of leading zero bits to exercise both boundary parities. It mixes random loss with directed cases: clean streams, a single lost word, and alternating loss that must never lock.

// File: rtl/lvds_deser7.sv
module lvds_deser7 #(
  parameter logic [6:0] SYNC_PAT = 7'b1100011
) (
  input  logic       clk_fast,
  input  logic       rst_n,
  input  logic [3:0] dat_rise,
  input  logic [3:0] dat_fall,
  input  logic       ck_rise,
  input  logic       ck_fall,
  output logic [7:0] pix_a,
  output logic [7:0] pix_b,
  output logic [7:0] pix_c,
  output logic       fval,
  output logic       lval,
  output logic       dval,
  output logic       spare,
  output logic       word_valid,
  output logic       word_odd,
  output logic       locked
);

  localparam int LANES = 4;
  localparam int GRP   = 7;
  localparam int WORD  = LANES * GRP;
  localparam int WIN   = GRP + 1;

  typedef enum logic [1:0] {HUNT, CONFIRM, TRACK} fsm_t;

  logic [WIN-1:0]  dsr [LANES];
  logic [WIN-1:0]  csr;
  logic [WORD-1:0] w_even, w_odd, w_sel, w_out;
  fsm_t            st;
  logic [1:0]      cnt;
  logic            nxt_odd;

  always_ff @(posedge clk_fast) begin
    if (!rst_n) csr <= '0;
    else        csr <= {csr[WIN-3:0], ck_rise, ck_fall};
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_fast) begin
      if (!rst_n) dsr[g] <= '0;
      else        dsr[g] <= {dsr[g][WIN-3:0], dat_rise[g], dat_fall[g]};
    end
    for (genvar i = 0; i < GRP; i++) begin : g_bit
      assign w_even[GRP*g+i] = dsr[g][GRP-1-i];
      assign w_odd[GRP*g+i]  = dsr[g][GRP-i];
    end
  end

  wire match_e   = (csr[GRP-1:0] == SYNC_PAT);
  wire match_o   = (csr[GRP:1]   == SYNC_PAT);
  wire boundary  = (st != HUNT) && (cnt == 2'd0);
  wire exp_match = nxt_odd ? match_o : match_e;
  assign w_sel   = nxt_odd ? w_odd : w_even;

  always_ff @(posedge clk_fast) begin
    if (!rst_n) begin
      st         <= HUNT;
      cnt        <= '0;
      nxt_odd    <= 1'b0;
      word_valid <= 1'b0;
      word_odd   <= 1'b0;
      locked     <= 1'b0;
      w_out      <= '0;
    end else begin
      word_valid <= 1'b0;
      if (st == HUNT) begin
        if (match_e) begin
          st      <= CONFIRM;
          nxt_odd <= 1'b1;
          cnt     <= 2'd3;
        end else if (match_o) begin
          st      <= CONFIRM;
          nxt_odd <= 1'b0;
          cnt     <= 2'd2;
        end
      end else if (boundary) begin
        if (exp_match) begin
          st         <= TRACK;
          nxt_odd    <= ~nxt_odd;
          cnt        <= nxt_odd ? 2'd2 : 2'd3;
          word_valid <= 1'b1;
          word_odd   <= nxt_odd;
          w_out      <= w_sel;
          locked     <= 1'b1;
        end else begin
          st     <= HUNT;
          locked <= 1'b0;
        end
      end else begin
        cnt <= cnt - 2'd1;
      end
    end
  end

  assign pix_a = w_out[7:0];
  assign pix_b = w_out[15:8];
  assign pix_c = w_out[23:16];
  assign fval  = w_out[24];
  assign lval  = w_out[25];
  assign dval  = w_out[26];
  assign spare = w_out[27];

endmodule

// File: rtl/lvds_deser7_chk.sv
module lvds_deser7_chk (
  input logic clk,
  input logic rst_n,
  input logic word_valid,
  input logic word_odd,
  input logic locked
);

  logic       seen;
  logic       last_odd;
  logic [2:0] gap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen     <= 1'b0;
      last_odd <= 1'b0;
      gap      <= '0;
    end else if (word_valid) begin
      seen     <= 1'b1;
      last_odd <= word_odd;
      gap      <= 3'd1;
    end else if (!locked) begin
      seen <= 1'b0;
    end else if (gap != 3'd7) begin
      gap <= gap + 3'd1;
    end
  end

  a_r3_valid_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> locked);

  a_r3_lock_rises_with_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> word_valid);

  a_r6_odd_alternates: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && seen) |-> (word_odd != last_odd));

  a_r5_gap_by_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && seen) |-> (gap == (last_odd ? 3'd3 : 3'd4)));

endmodule

bind lvds_deser7 lvds_deser7_chk u_chk (
  .clk        (clk_fast),
  .rst_n      (rst_n),
  .word_valid (word_valid),
  .word_odd   (word_odd),
  .locked     (locked)
);

// File: tb/sim_lvds_deser7.sv
module sim_lvds_deser7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] dat_rise = '0, dat_fall = '0;
  logic       ck_rise = 1'b0, ck_fall = 1'b0;
  logic [7:0] pix_a, pix_b, pix_c;
  logic       fval, lval, dval, spare, word_valid, word_odd, locked;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  localparam logic [6:0] SYNC = 7'b1100011;

  logic [4:0]  bq[$];
  int          exp_idx[$];
  logic        exp_odd[$];
  logic [27:0] exp_word[$];
  int          prev_idx = -10;
  logic        prev_odd = 1'b0;
  int          prev_cyc = 0;
  int          seed_dummy;

  always #2.5 clk = ~clk;

  lvds_deser7 u0 (
    .clk_fast(clk), .rst_n(rst_n), .dat_rise(dat_rise), .dat_fall(dat_fall),
    .ck_rise(ck_rise), .ck_fall(ck_fall), .pix_a(pix_a), .pix_b(pix_b),
    .pix_c(pix_c), .fval(fval), .lval(lval), .dval(dval), .spare(spare),
    .word_valid(word_valid), .word_odd(word_odd), .locked(locked)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual cycle %0d, expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Monitor: R3, R5, R6, R7 compared word by word against the bench model
  always @(negedge clk) begin
    if (rst_n && word_valid) begin
      checks = checks + 1;
      if (exp_word.size() == 0) begin
        fails = fails + 1;
        $display("FAIL R3 unexpected word: actual %h, expected no word",
                 {spare, dval, lval, fval, pix_c, pix_b, pix_a});
      end else begin
        automatic int          i  = exp_idx.pop_front();
        automatic logic        eo = exp_odd.pop_front();
        automatic logic [27:0] ew = exp_word.pop_front();
        automatic logic [27:0] aw = {spare, dval, lval, fval, pix_c, pix_b, pix_a};
        if (aw !== ew) begin
          fails = fails + 1;
          $display("FAIL R7 word %0d: actual %h, expected %h", i, aw, ew);
        end
        checks = checks + 1;
        if (word_odd !== eo) begin
          fails = fails + 1;
          $display("FAIL R6 word %0d parity: actual %0b, expected %0b", i, word_odd, eo);
        end
        if (prev_idx == i - 1) begin
          checks = checks + 1;
          if ((cyc - prev_cyc) != (prev_odd ? 3 : 4)) begin
            fails = fails + 1;
            $display("FAIL R5 gap before word %0d: actual %0d, expected %0d",
                     i, cyc - prev_cyc, prev_odd ? 3 : 4);
          end
        end
        prev_idx = i;
        prev_odd = eo;
        prev_cyc = cyc;
      end
    end
  end

  function automatic bit is_good(int mode, int i);
    case (mode)
      0: return 1'b1;
      1: return ($urandom % 6) != 0;
      2: return (i % 2) == 0;
      default: return i != 6;
    endcase
  endfunction

  // R1 and R2: the bit stream is built in time order, and the clock group marks the boundary
  task automatic build(int s, int nwords, int mode);
    int st = 0;
    bq.delete();
    exp_idx.delete(); exp_odd.delete(); exp_word.delete();
    prev_idx = -10;
    for (int k = 0; k < s; k++) bq.push_back(5'b0);
    for (int i = 0; i < nwords; i++) begin
      automatic logic [27:0] d  = 28'($urandom);
      automatic bit          g  = is_good(mode, i);
      automatic logic        od = (((s + 7*i + 6) % 2) == 0);
      for (int b = 0; b < 7; b++) begin
        automatic logic [4:0] v;
        for (int l = 0; l < 4; l++) v[l] = d[7*l + b];
        v[4] = g ? SYNC[6-b] : 1'b0;
        bq.push_back(v);
      end
      case (st)
        0: if (g) st = 1;
        1: if (g) begin st = 2; exp_idx.push_back(i); exp_odd.push_back(od); exp_word.push_back(d); end
           else st = 0;
        default: if (g) begin exp_idx.push_back(i); exp_odd.push_back(od); exp_word.push_back(d); end
                 else st = 0;
      endcase
    end
    if (bq.size() % 2 != 0) bq.push_back(5'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    dat_rise = '0; dat_fall = '0; ck_rise = 1'b0; ck_fall = 1'b0;
    repeat (3) @(negedge clk);
    checks = checks + 1;
    if (locked !== 1'b0 || word_valid !== 1'b0 || word_odd !== 1'b0 ||
        {spare, dval, lval, fval, pix_c, pix_b, pix_a} !== 28'h0) begin
      fails = fails + 1;
      $display("FAIL R8 reset: actual locked=%0b valid=%0b word=%h, expected all zero",
               locked, word_valid, {spare, dval, lval, fval, pix_c, pix_b, pix_a});
    end
    rst_n = 1'b1;
  endtask

  task automatic run(int s, int nwords, int mode, string tag);
    do_reset();
    build(s, nwords, mode);
    while (bq.size() > 0) begin
      automatic logic [4:0] a = bq.pop_front();
      automatic logic [4:0] b = bq.pop_front();
      @(negedge clk);
      dat_rise = a[3:0]; ck_rise = a[4];
      dat_fall = b[3:0]; ck_fall = b[4];
    end
    @(negedge clk);
    dat_rise = '0; dat_fall = '0; ck_rise = 1'b0; ck_fall = 1'b0;
    repeat (12) @(negedge clk);
    // R3 and R4: every word the model expects has been emitted
    checks = checks + 1;
    if (exp_word.size() != 0) begin
      fails = fails + 1;
      $display("FAIL R4 %s: actual %0d words missing, expected 0", tag, exp_word.size());
    end
  endtask

  initial begin
    seed_dummy = $urandom(32'd7319);
    run(0, 12, 0, "clean even start");
    run(1, 12, 0, "clean odd start");
    run(3, 14, 2, "alternating loss never locks");
    run(2, 16, 3, "single lost word");
    for (int t = 0; t < 20; t++) run(int'($urandom % 14), 40, 1, "random loss");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule